// File: doc/BRIEF.md
# Reset Sequencer with Programmable Delay Timer

This block generates the internal chip reset. Three conditions can request it: an active-low external master clear pin, a synchronous power-on pulse, and a flag from a supply comparator that reports a brown-out (supply below threshold). The reset stays asserted while any of them is present. Once the last one goes away, a delay timer runs for a period set by a 2-bit select field, and reset drops only when that period has elapsed. If any source returns during the countdown, the count starts again from zero.

The same timer also sequences the exit from power-down. A wake request arriving while the chip is running starts a countdown with the same selected period. During that countdown the busy flag is high, but reset itself stays low. The timer measures time from the request and nothing else. It has no knowledge of the true supply level, so when the supply ramps slowly the release can come before the supply is valid. Configuration bits can disable brown-out holding entirely. The clock frequency is a parameter, and each timeout's cycle count is derived from it.

Top module: `reset_sequencer`

## Requirements
- R1: A high `por_pulse` at a clock edge sets `rst_out` and `tmr_busy` high after that same edge. Both stay high on every cycle in which any reset source is active.
- R2: When all sources have cleared, `rst_out` stays high for exactly N further cycles and then falls on the cycle after the timer reaches its terminal count. N depends on `dly_sel`: 2'b10 gives CLK_HZ/4000 (0.25 ms), 2'b11 gives 18*CLK_HZ/1000 (18 ms, the default fuse value), 2'b00 gives 60*CLK_HZ/1000 (60 ms) and 2'b01 gives CLK_HZ (1 s). N is never less than 1.
- R3: When brown-out holding is enabled, a high `bo_low` keeps `rst_out` asserted with no time limit. The timed release begins only after `bo_low` clears.
- R4: With `bo_cfg` equal to 2'b11, brown-out holding is disabled and `bo_low` has no effect on `rst_out` or `tmr_busy`. Every other `bo_cfg` value enables it.
- R5: A `wake_req` seen while the sequencer is idle (`tmr_busy` low, no source active) sets `tmr_busy` high for exactly N cycles, with N chosen by `dly_sel` as in R2. `rst_out` stays low during this time.
- R6: A reset source that becomes active during a reset or wake countdown returns the block to holding reset. The full period is then counted again from zero after the source clears. When a source and `wake_req` arrive in the same cycle, the reset takes priority.
- R7: The delay period is captured when a countdown begins. Changing `dly_sel` during the countdown does not change its length.
- R8: A `wake_req` is ignored while `tmr_busy` is high.
- R9: `mclr_n` and `bo_low` each pass through a two-flop synchronizer. A change on either pin takes effect on the outputs two clock edges later than a `por_pulse` change would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, frequency CLK_HZ |
| por_pulse | input | 1 | Power-on indication, active high, synchronous |
| mclr_n | input | 1 | External master clear, active low, asynchronous |
| bo_low | input | 1 | Brown-out comparator flag, high when the supply is below threshold |
| bo_cfg | input | 2 | Brown-out holding configuration; 2'b11 disables it |
| dly_sel | input | 2 | Delay period select |
| wake_req | input | 1 | Request to leave power-down |
| rst_out | output | 1 | Internal chip reset, active high |
| tmr_busy | output | 1 | High while reset is held or any countdown is running |

## Verification
Two functions can fall in the same cycle: a wake countdown and a new reset request. They collide in two ways. A reset source can reach the sequencer on the very edge where `wake_req` is sampled, which happens when `por_pulse` and `wake_req` are raised together, or when `mclr_n` falls two cycles before the wake request so that its synchronized value arrives on that edge. A brown-out can also appear in the middle of a wake countdown. In each case the cycle-by-cycle reference model predicts reset priority: `rst_out` must rise on the collision edge, and the full reset period must be counted afterward. Every cycle is compared against that prediction, so an early or late release of even one cycle is flagged.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_COUNT = 2'd2,
        ST_WAKE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       rst;
        logic       busy;
    } seq_t;

    // Configuration value that switches brown-out holding off
    localparam logic [1:0] BO_CFG_OFF = 2'b11;

    // Select encodings, the order is defined by the fuse field
    localparam logic [1:0] SEL_60MS  = 2'b00;
    localparam logic [1:0] SEL_1S    = 2'b01;
    localparam logic [1:0] SEL_250US = 2'b10;
    localparam logic [1:0] SEL_18MS  = 2'b11;

    function automatic longint unsigned delay_cycles(
        input longint unsigned clk_hz,
        input logic [1:0]      sel
    );
        longint unsigned n;
        case (sel)
            SEL_250US: n = clk_hz / 4000;
            SEL_18MS:  n = (clk_hz * 18) / 1000;
            SEL_60MS:  n = (clk_hz * 60) / 1000;
            default:   n = clk_hz;
        endcase
        if (n == 0) n = 1;
        return n;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d;
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_comb begin
        stg_d[0] = din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/rstseq_src.sv
module rstseq_src
    import rstseq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       mclr_n,
    input  logic       bo_low,
    input  logic [1:0] bo_cfg,
    output logic       mclr_act,
    output logic       bo_act,
    output logic       src_act
);

    logic [1:0] pins_sync;
    logic       bo_enabled;

    rstseq_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk  (clk),
        .din  ({bo_low, mclr_n}),
        .dout (pins_sync)
    );

    always_comb begin
        bo_enabled = (bo_cfg != BO_CFG_OFF);
        mclr_act   = ~pins_sync[0];
        bo_act     = pins_sync[1] & bo_enabled;
        src_act    = por_pulse | mclr_act | bo_act;
    end

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int unsigned CLK_HZ = 1_000_000,
    localparam int unsigned CW = $clog2(CLK_HZ + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       done
);

    localparam logic [CW-1:0] LIM_250US = CW'(delay_cycles(CLK_HZ, SEL_250US));
    localparam logic [CW-1:0] LIM_18MS  = CW'(delay_cycles(CLK_HZ, SEL_18MS));
    localparam logic [CW-1:0] LIM_60MS  = CW'(delay_cycles(CLK_HZ, SEL_60MS));
    localparam logic [CW-1:0] LIM_1S    = CW'(delay_cycles(CLK_HZ, SEL_1S));

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } tm_t;

    tm_t           tm_d;
    tm_t           tm_q;
    logic [CW-1:0] lim_sel;

    always_comb begin
        case (sel)
            SEL_250US: lim_sel = LIM_250US;
            SEL_18MS:  lim_sel = LIM_18MS;
            SEL_60MS:  lim_sel = LIM_60MS;
            default:   lim_sel = LIM_1S;
        endcase
    end

    always_comb begin
        done = (tm_q.cnt == (tm_q.lim - CW'(1)));
        tm_d = tm_q;
        if (load) begin
            tm_d.cnt = '0;
            tm_d.lim = lim_sel;
        end else if (run && !done) begin
            tm_d.cnt = tm_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q <= '{cnt: '0, lim: LIM_18MS};
        end else begin
            tm_q <= tm_d;
        end
    end

    AST_CNT_BELOW_LIM: assert property (@(posedge clk) disable iff (rst)
        tm_q.cnt < tm_q.lim) else $error("count passed limit"); // R2

    AST_LIM_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(tm_q.lim)) else $error("limit changed mid count"); // R7

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 1_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       mclr_n,
    input  logic       bo_low,
    input  logic [1:0] bo_cfg,
    input  logic [1:0] dly_sel,
    input  logic       wake_req,
    output logic       rst_out,
    output logic       tmr_busy
);

    logic mclr_act;
    logic bo_act;
    logic src_act;
    logic tm_load;
    logic tm_run;
    logic tm_done;
    seq_t seq_d;
    seq_t seq_q;

    rstseq_src #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_src (
        .clk       (clk),
        .por_pulse (por_pulse),
        .mclr_n    (mclr_n),
        .bo_low    (bo_low),
        .bo_cfg    (bo_cfg),
        .mclr_act  (mclr_act),
        .bo_act    (bo_act),
        .src_act   (src_act)
    );

    rstseq_timer #(
        .CLK_HZ (CLK_HZ)
    ) i_timer (
        .clk  (clk),
        .rst  (por_pulse),
        .load (tm_load),
        .run  (tm_run),
        .sel  (dly_sel),
        .done (tm_done)
    );

    always_comb begin
        seq_d   = seq_q;
        tm_load = 1'b0;
        tm_run  = 1'b0;
        if (src_act) begin
            seq_d.st = ST_HOLD;
        end else begin
            case (seq_q.st)
                ST_HOLD: begin
                    seq_d.st = ST_COUNT;
                    tm_load  = 1'b1;
                end
                ST_COUNT, ST_WAKE: begin
                    if (tm_done) seq_d.st = ST_RUN;
                    else         tm_run   = 1'b1;
                end
                default: begin
                    if (wake_req) begin
                        seq_d.st = ST_WAKE;
                        tm_load  = 1'b1;
                    end
                end
            endcase
        end
        seq_d.rst  = (seq_d.st == ST_HOLD) || (seq_d.st == ST_COUNT);
        seq_d.busy = (seq_d.st != ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (por_pulse) begin
            seq_q <= '{st: ST_HOLD, rst: 1'b1, busy: 1'b1};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rst_out  = seq_q.rst;
    assign tmr_busy = seq_q.busy;

    AST_SRC_FORCES_RST: assert property (@(posedge clk) disable iff (por_pulse)
        src_act |=> rst_out) else $error("source without reset"); // R1

    AST_RST_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (por_pulse)
        rst_out |-> tmr_busy) else $error("reset without busy"); // R1

    AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (por_pulse)
        $fell(rst_out) |-> ($past(tm_done) && !$past(src_act)))
        else $error("early reset release"); // R2

    AST_WAKE_NO_RST: assert property (@(posedge clk) disable iff (por_pulse)
        (seq_q.st == ST_RUN && wake_req && !src_act) |=> (tmr_busy && !rst_out))
        else $error("wake raised reset"); // R5

    AST_BO_MASKED: assert property (@(posedge clk) disable iff (por_pulse)
        (bo_cfg == BO_CFG_OFF && !mclr_act && seq_q.st == ST_RUN && !wake_req) |=> !rst_out)
        else $error("disabled brown-out held reset"); // R4

endmodule

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int TB_HZ      = 4000;
    localparam int WDOG_MAX   = 100000;

    logic       clk = 1'b0;
    logic       por_pulse = 1'b1;
    logic       mclr_n = 1'b1;
    logic       bo_low = 1'b0;
    logic [1:0] bo_cfg = 2'b00;
    logic [1:0] dly_sel = 2'b11;
    logic       wake_req = 1'b0;
    logic       rst_out;
    logic       tmr_busy;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // reference model state
    int m_st = 1;
    int m_cnt = 0;
    int m_lim = 1;
    bit m_rst = 1'b1;
    bit m_busy = 1'b1;
    bit m_live = 1'b0;
    bit mq[$] = '{1'b1, 1'b1};
    bit bq[$] = '{1'b0, 1'b0};

    reset_sequencer #(.CLK_HZ(TB_HZ)) i_reset_sequencer (
        .clk       (clk),
        .por_pulse (por_pulse),
        .mclr_n    (mclr_n),
        .bo_low    (bo_low),
        .bo_cfg    (bo_cfg),
        .dly_sel   (dly_sel),
        .wake_req  (wake_req),
        .rst_out   (rst_out),
        .tmr_busy  (tmr_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_of(input logic [1:0] s);
        int n;
        case (s)
            2'b10:   n = TB_HZ / 4000;
            2'b11:   n = TB_HZ * 18 / 1000;
            2'b00:   n = TB_HZ * 60 / 1000;
            default: n = TB_HZ;
        endcase
        return (n < 1) ? 1 : n;
    endfunction

    // behavioural model, one step per rising edge
    always @(posedge clk) begin
        bit m_sync;
        bit b_sync;
        bit src;
        m_sync = mq.pop_front();
        b_sync = bq.pop_front();
        src = por_pulse || !m_sync || (b_sync && bo_cfg != 2'b11);
        if (por_pulse) m_live = 1'b1;
        if (src) begin
            m_st = 1;
        end else if (m_st == 1) begin
            m_st = 2; m_cnt = 0; m_lim = period_of(dly_sel);
        end else if (m_st == 2 || m_st == 3) begin
            if (m_cnt == m_lim - 1) m_st = 0;
            else m_cnt++;
        end else if (wake_req) begin
            m_st = 3; m_cnt = 0; m_lim = period_of(dly_sel);
        end
        m_rst  = (m_st == 1 || m_st == 2);
        m_busy = (m_st != 0);
        mq.push_back(mclr_n);
        bq.push_back(bo_low);
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (m_live) begin
            n_cmp++;
            if (rst_out !== m_rst || tmr_busy !== m_busy) begin
                n_bad++;
                $display("FAIL %s cycle %0d: rst/busy actual %b%b expected %b%b",
                         cur_req, cyc, rst_out, tmr_busy, m_rst, m_busy);
            end
        end
        if (cyc > WDOG_MAX) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mclr_pulse(input int len);
        mclr_n = 1'b0; step(len); mclr_n = 1'b1;
    endtask

    initial begin
        // R1 power-on, R2 default 18 ms period
        cur_req = "R1"; step(5); por_pulse = 1'b0;
        cur_req = "R2"; step(100);
        // R9 master clear latency, R2 each encoding
        cur_req = "R9"; mclr_pulse(4);
        cur_req = "R2"; step(100);
        dly_sel = 2'b10; mclr_pulse(3); step(20);
        dly_sel = 2'b00; mclr_pulse(3); step(300);
        dly_sel = 2'b01; mclr_pulse(3); step(4100);
        // R3 brown-out holds indefinitely
        dly_sel = 2'b11; bo_cfg = 2'b01; cur_req = "R3";
        bo_low = 1'b1; step(500); bo_low = 1'b0; step(100);
        bo_cfg = 2'b10; bo_low = 1'b1; step(50); bo_low = 1'b0; step(100);
        // R4 brown-out disabled
        bo_cfg = 2'b11; cur_req = "R4";
        bo_low = 1'b1; step(200); bo_low = 1'b0; step(10);
        bo_cfg = 2'b00;
        // R5 wake countdown, R8 ignored repeat
        cur_req = "R5"; wake_req = 1'b1; step(1); wake_req = 1'b0; step(20);
        cur_req = "R8"; wake_req = 1'b1; step(1); wake_req = 1'b0; step(80);
        dly_sel = 2'b10; cur_req = "R5"; wake_req = 1'b1; step(1); wake_req = 1'b0; step(10);
        dly_sel = 2'b11;
        // R6 restart during countdown
        cur_req = "R6"; mclr_pulse(2); step(40); mclr_pulse(2); step(100);
        // R7 select change mid count
        cur_req = "R7"; mclr_pulse(2); step(5); dly_sel = 2'b01; step(100); dly_sel = 2'b11;
        // R6 collisions with wake
        cur_req = "R6"; por_pulse = 1'b1; wake_req = 1'b1; step(1);
        por_pulse = 1'b0; wake_req = 1'b0; step(100);
        mclr_n = 1'b0; step(2); wake_req = 1'b1; step(1); wake_req = 1'b0;
        mclr_n = 1'b1; step(100);
        wake_req = 1'b1; step(1); wake_req = 1'b0; step(30);
        bo_low = 1'b1; step(5); bo_low = 1'b0; step(100);
        finish_run();
    end

endmodule